// File: doc/BRIEF.md
# Indexed Register Gather Sequencer

This block carries out an indexed move across a small register file, one element per clock. For every destination element it fetches an index, adds it to the destination base register number, reads that register and writes the value into the next destination register. Indices can be stored one per register, or packed several to a register at 8, 16 or 32 bits each, so that a short list of offsets fits in one word.

A 4-bit function code chooses the index width and the offset mode. In flat mode the index position advances with every element of the whole operation. In sub-vector mode it restarts at zero for every outer element, so the same small offset pattern is applied to each sub-vector. With that pattern a transposition can be done as a gather. The block drives two asynchronous read ports and one write port of an external register file. It starts on a one-cycle start strobe and reports completion with a one-cycle done pulse.

Top module: `gather_seq`

## Requirements
- R1: A start is accepted only when fn_i[1:0] is 2'b01 (flat mode) or 2'b11 (sub-vector mode). A start with fn_i[0]=0, including code 4'b0000, sets no busy, no done and no write.
- R2: fn_i[3:2] selects the index width: 0 gives XLEN bits, 1 gives 8, 2 gives 16 and 3 gives 32 bits. A width larger than XLEN is cut to XLEN.
- R3: Index number n is taken from register rs1 + n/P, where P = XLEN/width, at slot n%P. Slot 0 is the least significant. With 8-bit indices, rs1 holding 0x00020301 and VL=4, the indices are 1, 3, 2, 0.
- R4: Element e, counting from 0 to VL*SUBVL-1, writes register rd+e with the contents of register rd+index. The read sees the writes of earlier elements of the same operation.
- R5: In flat mode the index position of element e is e.
- R6: In sub-vector mode the index position is e mod SUBVL. It restarts at 0 for every outer element.
- R7: busy_o is high for exactly VL*SUBVL cycles, starting in the cycle after the accepted start. Writes happen only while busy_o is high.
- R8: done_o is high for a single cycle, the cycle after the last element. busy_o is low during that cycle.
- R9: If the index register number, the source register number or the destination register number is NREGS or more, that element is not written and err_o is set. err_o holds until the next accepted start, which clears it.
- R10: A start that arrives while busy_o is high is ignored. The running operation finishes with the parameters it was started with.
- R11: If VL*SUBVL is 0, nothing is written, busy_o stays low and done_o pulses in the cycle after the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe |
| fn_i | input | 4 | Function code: [3:2] index width, [1:0] mode |
| rd_i | input | AW | Destination base register number |
| rs1_i | input | AW | First register of the index storage |
| vl_i | input | VLW | Outer element count |
| subvl_i | input | SVW | Inner sub-vector length |
| busy_o | output | 1 | An operation is running |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Sticky out-of-range flag |
| idx_addr_o | output | AW | Read port A address (index register) |
| idx_data_i | input | XLEN | Read port A data |
| src_addr_o | output | AW | Read port B address (source register) |
| src_data_i | input | XLEN | Read port B data |
| wr_en_o | output | 1 | Register file write enable |
| wr_addr_o | output | AW | Write address |
| wr_data_o | output | XLEN | Write data |

## Verification
The hardest case to reach from the ports is a gather in which a later element reads a register that an earlier element of the same operation has already overwritten. The result is only right if the read port is combinational and the writes land one at a time. The stimulus places the destination window over the source window on purpose, with packed indices that point back into registers already written. The bench compares the whole register file against a sequential model. A second case that is hard to reach is a start strobe that arrives in the middle of a run. The bench raises it in the first busy cycle with different parameters and checks that the outcome is that of the first command alone.

// File: rtl/gather_pkg.sv
package gather_pkg;
  typedef enum logic {MODE_FLAT = 1'b0, MODE_SUB = 1'b1} ofs_mode_e;

  // log2 of index width in bits, clamped to the register width
  function automatic int lg_width(logic [1:0] code, int lg_xlen);
    int w;
    case (code)
      2'd1:    w = 3;
      2'd2:    w = 4;
      2'd3:    w = 5;
      default: w = lg_xlen;
    endcase
    return (w > lg_xlen) ? lg_xlen : w;
  endfunction
endpackage

// File: rtl/gather_ctrl.sv
module gather_ctrl
  import gather_pkg::*;
#(
  parameter int VLW = 6,
  parameter int SVW = 3,
  localparam int PW = VLW + SVW
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           fn_ok_i,
  input  ofs_mode_e      mode_i,
  input  logic [VLW-1:0] vl_i,
  input  logic [SVW-1:0] subvl_i,
  output logic           accept_o,
  output logic           run_o,
  output logic           done_o,
  output logic [PW-1:0]  elem_o,
  output logic [PW-1:0]  pos_o
);
  logic [PW-1:0]  total_q, e_q, total_d;
  logic [SVW-1:0] j_q, sub_q;
  ofs_mode_e      mode_q;
  logic           run_q, done_q, last;

  assign accept_o = start_i & fn_ok_i & ~run_q;
  assign total_d  = PW'(vl_i) * PW'(subvl_i);
  assign last     = (e_q == total_q - PW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      total_q <= '0;
      e_q     <= '0;
      j_q     <= '0;
      sub_q   <= '0;
      mode_q  <= MODE_FLAT;
      run_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept_o) begin
        total_q <= total_d;
        sub_q   <= subvl_i;
        mode_q  <= mode_i;
        e_q     <= '0;
        j_q     <= '0;
        run_q   <= (total_d != '0);
        done_q  <= (total_d == '0);
      end else if (run_q) begin
        if (last) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end else begin
          e_q <= e_q + PW'(1);
          j_q <= (j_q == SVW'(sub_q - SVW'(1))) ? '0 : j_q + SVW'(1);
        end
      end
    end
  end

  assign run_o  = run_q;
  assign done_o = done_q;
  assign elem_o = e_q;
  assign pos_o  = (mode_q == MODE_SUB) ? PW'(j_q) : e_q;
endmodule

// File: rtl/gather_idx.sv
module gather_idx
  import gather_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int NREGS = 32,
  parameter int PW    = 9,
  localparam int AW   = $clog2(NREGS),
  localparam int LGX  = $clog2(XLEN),
  localparam int CW   = PW + AW + 1
) (
  input  logic [PW-1:0]   pos_i,
  input  logic [1:0]      wcode_i,
  input  logic [AW-1:0]   rs1_i,
  input  logic [XLEN-1:0] data_i,
  output logic [AW-1:0]   addr_o,
  output logic            ok_o,
  output logic [XLEN-1:0] idx_o
);
  localparam logic [XLEN:0] ONE_X = (XLEN+1)'(1);

  int            lw, lp, sh;
  logic [PW-1:0] roff, slot;
  logic [CW-1:0] reg_num;
  logic [XLEN:0] mask_w;

  always_comb begin
    lw      = lg_width(wcode_i, LGX);
    lp      = LGX - lw;
    roff    = pos_i >> lp;
    slot    = pos_i & PW'((PW'(1) << lp) - PW'(1));
    sh      = int'(slot) << lw;
    reg_num = CW'(rs1_i) + CW'(roff);
    mask_w  = (ONE_X << (1 << lw)) - ONE_X;
    ok_o    = reg_num < CW'(NREGS);
    addr_o  = reg_num[AW-1:0];
    idx_o   = (data_i >> sh) & mask_w[XLEN-1:0];
  end
endmodule

// File: rtl/gather_seq.sv
module gather_seq
  import gather_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int NREGS = 32,
  parameter int VLW   = 6,
  parameter int SVW   = 3,
  localparam int AW   = $clog2(NREGS),
  localparam int PW   = VLW + SVW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [3:0]      fn_i,
  input  logic [AW-1:0]   rd_i,
  input  logic [AW-1:0]   rs1_i,
  input  logic [VLW-1:0]  vl_i,
  input  logic [SVW-1:0]  subvl_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            err_o,
  output logic [AW-1:0]   idx_addr_o,
  input  logic [XLEN-1:0] idx_data_i,
  output logic [AW-1:0]   src_addr_o,
  input  logic [XLEN-1:0] src_data_i,
  output logic            wr_en_o,
  output logic [AW-1:0]   wr_addr_o,
  output logic [XLEN-1:0] wr_data_o
);
  localparam int SW = XLEN + 1;
  localparam int DW = PW + AW + 1;

  logic            accept, run, idx_ok, src_ok, dst_ok, el_ok, err_q;
  logic [PW-1:0]   elem, pos;
  logic [AW-1:0]   rd_q, rs1_q;
  logic [1:0]      wcode_q;
  logic [XLEN-1:0] idx_val;
  logic [SW-1:0]   src_num;
  logic [DW-1:0]   dst_num;

  gather_ctrl #(.VLW(VLW), .SVW(SVW)) i_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .fn_ok_i  (fn_i[0]),
    .mode_i   (fn_i[1] ? MODE_SUB : MODE_FLAT),
    .vl_i     (vl_i),
    .subvl_i  (subvl_i),
    .accept_o (accept),
    .run_o    (run),
    .done_o   (done_o),
    .elem_o   (elem),
    .pos_o    (pos)
  );

  gather_idx #(.XLEN(XLEN), .NREGS(NREGS), .PW(PW)) i_idx (
    .pos_i   (pos),
    .wcode_i (wcode_q),
    .rs1_i   (rs1_q),
    .data_i  (idx_data_i),
    .addr_o  (idx_addr_o),
    .ok_o    (idx_ok),
    .idx_o   (idx_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q    <= '0;
      rs1_q   <= '0;
      wcode_q <= '0;
    end else if (accept) begin
      rd_q    <= rd_i;
      rs1_q   <= rs1_i;
      wcode_q <= fn_i[3:2];
    end
  end

  assign src_num = SW'(rd_q) + SW'(idx_val);
  assign dst_num = DW'(rd_q) + DW'(elem);
  assign src_ok  = src_num < SW'(NREGS);
  assign dst_ok  = dst_num < DW'(NREGS);
  assign el_ok   = idx_ok & src_ok & dst_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                err_q <= 1'b0;
    else if (accept)            err_q <= 1'b0;
    else if (run && !el_ok)     err_q <= 1'b1;
  end

  assign src_addr_o = src_num[AW-1:0];
  assign wr_en_o    = run & el_ok;
  assign wr_addr_o  = dst_num[AW-1:0];
  assign wr_data_o  = src_data_i;
  assign busy_o     = run;
  assign err_o      = err_q;
endmodule

// File: rtl/gather_seq_chk.sv
module gather_seq_chk #(
  parameter int XLEN  = 32,
  parameter int NREGS = 32,
  parameter int VLW   = 6,
  parameter int SVW   = 3,
  localparam int AW   = $clog2(NREGS)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic [3:0]    fn_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          err_o,
  input logic          wr_en_o,
  input logic [AW-1:0] wr_addr_o
);
  logic acc;
  assign acc = start_i & ~busy_o & fn_i[0];

  AST_WR_WHEN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> busy_o);  // R7
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);  // R8
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && !wr_en_o));  // R8
  AST_BAD_FN_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && !fn_i[0]) |=> (!busy_o && !done_o));  // R1
  AST_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> (busy_o || done_o));  // R10
  AST_ERR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> !err_o);  // R9
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !acc) |=> err_o);  // R9
  AST_DST_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && $past(wr_en_o)) |-> (wr_addr_o == AW'($past(wr_addr_o) + AW'(1))));  // R4
endmodule

bind gather_seq gather_seq_chk #(
  .XLEN(XLEN), .NREGS(NREGS), .VLW(VLW), .SVW(SVW)
) i_gather_seq_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .fn_i      (fn_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .err_o     (err_o),
  .wr_en_o   (wr_en_o),
  .wr_addr_o (wr_addr_o)
);

// File: tb/test_gather_seq.sv
module test_gather_seq;
  localparam int XLEN = 32, NREGS = 32, VLW = 6, SVW = 3, AW = 5;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic            rst_n, start, busy, done, err, wr_en;
  logic [3:0]      fn;
  logic [AW-1:0]   rd, rs1, idx_addr, src_addr, wr_addr;
  logic [VLW-1:0]  vl;
  logic [SVW-1:0]  subvl;
  logic [XLEN-1:0] idx_data, src_data, wr_data;
  logic [XLEN-1:0] rf [NREGS];
  logic [XLEN-1:0] exp_rf [NREGS];
  int total_n = 0, bad_n = 0;

  gather_seq #(.XLEN(XLEN), .NREGS(NREGS), .VLW(VLW), .SVW(SVW)) i_gather_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .fn_i(fn), .rd_i(rd), .rs1_i(rs1),
    .vl_i(vl), .subvl_i(subvl), .busy_o(busy), .done_o(done), .err_o(err),
    .idx_addr_o(idx_addr), .idx_data_i(idx_data), .src_addr_o(src_addr),
    .src_data_i(src_data), .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data)
  );

  assign idx_data = rf[idx_addr];
  assign src_data = rf[src_addr];
  always @(posedge clk) if (wr_en) rf[wr_addr] <= wr_data;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    total_n++;
    if (!ok) begin
      bad_n++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic init_rf();
    for (int k = 0; k < NREGS; k++) rf[k] = 32'hA000 + k;
  endtask

  function automatic void model(int f, int d, int s, int v, int sb, output bit e_err, output int nwr);
    int wb, per, pos, ireg, slot, dst;
    longint idx, src, mask;
    e_err = 0; nwr = 0;
    case ((f >> 2) & 3)
      0: wb = XLEN;
      1: wb = 8;
      2: wb = 16;
      default: wb = 32;
    endcase
    if (wb > XLEN) wb = XLEN;
    per = XLEN / wb;
    mask = (64'd1 << wb) - 1;
    for (int e = 0; e < v * sb; e++) begin
      pos = ((f & 2) != 0) ? e % sb : e;
      ireg = s + pos / per;
      slot = pos % per;
      dst = d + e;
      if (ireg >= NREGS) begin e_err = 1; continue; end
      idx = (longint'(exp_rf[ireg]) >> (slot * wb)) & mask;
      src = d + idx;
      if (src >= NREGS || dst >= NREGS) e_err = 1;
      else begin exp_rf[dst] = exp_rf[src]; nwr++; end
    end
  endfunction

  task automatic run_op(int f, int d, int s, int v, int sb, string req, bit poke);
    bit e_err; int nwr, cyc = 0, wr = 0; bit seen_done = 0;
    for (int k = 0; k < NREGS; k++) exp_rf[k] = rf[k];
    model(f, d, s, v, sb, e_err, nwr);
    @(negedge clk);
    start = 1; fn = 4'(f); rd = AW'(d); rs1 = AW'(s); vl = VLW'(v); subvl = SVW'(sb);
    for (int t = 0; t < 600; t++) begin
      @(negedge clk);
      start = 0;
      if (poke && t == 0) begin start = 1; rd = AW'(d + 3); fn = 4'b0001; vl = 6'd2; end
      if (busy) begin cyc++; if (wr_en) wr++; end
      else begin seen_done = done; break; end
    end
    start = 0;
    chk(cyc == v * sb, "R7", "busy cycles", cyc, v * sb);
    chk(wr == nwr, "R7", "write count", wr, nwr);
    chk(seen_done, "R8", "done after last", seen_done, 1);
    chk(err == e_err, "R9", "err flag", err, e_err);
    for (int k = 0; k < NREGS; k++)
      chk(rf[k] === exp_rf[k], req, $sformatf("reg %0d", k), rf[k], exp_rf[k]);
    @(negedge clk);
    chk(!done, "R8", "done single cycle", done, 0);
  endtask

  task automatic t_reset();
    rst_n = 0; start = 0; fn = 0; rd = 0; rs1 = 0; vl = 0; subvl = 0;
    init_rf();
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && !wr_en, "R7", "reset outputs", {busy, done, err, wr_en}, 0);
    rst_n = 1;
  endtask

  task automatic t_pack8();
    init_rf(); rf[1] = 32'h0002_0301;
    run_op(4'b0101, 8, 1, 4, 1, "R3", 0);
    chk(rf[8] == 32'hA009, "R3", "first packed index", rf[8], 32'hA009);
    chk(rf[11] == 32'hA009, "R4", "read after earlier write", rf[11], 32'hA009);
  endtask

  task automatic t_widths();
    init_rf(); rf[2] = 3; rf[3] = 0; rf[4] = 5;
    run_op(4'b0001, 10, 2, 3, 1, "R2", 0);
    init_rf(); rf[1] = 32'h0004_0002; rf[2] = 32'h0001_0003; rf[3] = 32'h0000_0006;
    run_op(4'b1001, 16, 1, 5, 1, "R3", 0);
    init_rf(); rf[1] = 2; rf[2] = 7;
    run_op(4'b1101, 20, 1, 2, 1, "R2", 0);
  endtask

  task automatic t_modes();
    init_rf(); rf[1] = 32'h0000_0102; rf[2] = 32'h0000_0304;
    run_op(4'b0111, 12, 1, 3, 2, "R6", 0);
    chk(rf[14] == 32'hA00E, "R6", "restart of index position", rf[14], 32'hA00E);
    init_rf(); rf[1] = 32'h0000_0102; rf[2] = 32'h0000_0304;
    run_op(4'b0101, 12, 1, 3, 2, "R5", 0);
  endtask

  task automatic t_bad_fn(logic [3:0] f);
    init_rf();
    @(negedge clk);
    start = 1; fn = f; rd = 4; rs1 = 1; vl = 3; subvl = 1;
    @(negedge clk); start = 0;
    for (int t = 0; t < 3; t++) begin
      chk(!busy && !done && !wr_en, "R1", "reserved code ignored", {busy, done, wr_en}, 0);
      @(negedge clk);
    end
    chk(rf[4] == 32'hA004, "R1", "reg untouched", rf[4], 32'hA004);
  endtask

  task automatic t_err();
    init_rf(); rf[1] = 32'h0000_1F01;
    run_op(4'b0101, 8, 1, 2, 1, "R9", 0);
    chk(err == 1, "R9", "src out of range", err, 1);
    @(negedge clk);
    chk(err == 1, "R9", "err sticky", err, 1);
    init_rf(); rf[1] = 0; rf[2] = 0; rf[3] = 0;
    run_op(4'b0001, 30, 1, 3, 1, "R9", 0);
    init_rf(); rf[1] = 32'h0000_0001;
    run_op(4'b0101, 2, 1, 1, 1, "R9", 0);
  endtask

  task automatic t_restart();
    init_rf(); rf[1] = 32'h0100_0102;
    run_op(4'b0101, 4, 1, 4, 1, "R10", 1);
  endtask

  task automatic t_zero();
    init_rf();
    run_op(4'b0101, 4, 1, 0, 1, "R11", 0);
    run_op(4'b0111, 4, 1, 3, 0, "R11", 0);
  endtask

  initial begin
    #(200000 * 10);
    total_n++; bad_n++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total_n, bad_n);
    $finish;
  end

  initial begin
    t_reset();
    t_pack8();
    t_widths();
    t_modes();
    t_bad_fn(4'b0000);
    t_bad_fn(4'b0110);
    t_err();
    t_restart();
    t_zero();
    $display("test done: total=%0d bad=%0d", total_n, bad_n);
    $finish;
  end
endmodule